// File: doc/BRIEF.md
# SDA Setup/Hold Timer for a Two-Wire Bus Controller

This block decides the cycle in which a two-wire bus controller may move its SDA output, measured against the SCL edges it observes. After SCL falls it holds the old data level for a minimum number of system clocks. It then drives the next bit and raises a ready flag once a minimum setup interval has passed, so that the SCL generator knows it may release SCL high. Two timing profiles exist: a normal one, with a short hold, and an extended one, with longer hold and setup, meant for fast system clocks. A single mode input selects between them.

Acknowledge bits and the first bit of each data byte are "gated" bits. Software must release them with a strobe before they go onto the wire. For these bits the setup interval is one system clock plus however long software takes. A release that arrives before the hold window ends, including one issued together with the bit value, adds no delay. The mode input is only taken while the bus has been idle for a run of cycles, so the profile cannot change in the middle of a bit.

Top module: `sda_setup_hold_timer`

## Requirements
- R1: The raw SCL level passes through a two-flop synchronizer. A raw change made just before clock edge 1 is acted on at clock edge 3.
- R2: In the normal profile the new SDA level appears exactly 3 clock edges after the edge that acts on SCL falling, and never earlier.
- R3: In the extended profile the new SDA level appears exactly 12 clock edges after the edge that acts on SCL falling.
- R4: In the extended profile, for a bit that is not gated, ready rises 11 clock edges after the edge that changed SDA.
- R5: In the normal profile, for a bit that is not gated, ready rises 1 clock edge after the edge that changed SDA.
- R6: A gated bit (gated_bit=1 when SCL falls) is not driven until the release strobe has been sampled. It is driven at the later of the hold expiry and the edge that samples the strobe, and ready rises 1 edge after that in either profile.
- R7: A release strobe given before or together with the SCL fall is kept, so a gated bit then behaves like an ordinary bit held for the hold time.
- R8: Ready drops at the edge that acts on SCL rising. SDA never changes while the synchronized SCL is high.
- R9: ext_mode (1 = extended, 0 = normal) is latched only after the synchronized SCL has been high for 10 consecutive cycles. A change made during a bit, or during a shorter high period, has no effect on the next bit's hold time.
- R10: After reset, sda_drive is 1, ready is 0 and the normal profile is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_raw | input | 1 | Observed SCL level, asynchronous |
| ext_mode | input | 1 | 1 selects the extended timing profile |
| data_bit | input | 1 | Next bit to place on SDA |
| gated_bit | input | 1 | 1 marks the next bit as needing a software release (ACK or MSB) |
| sw_release | input | 1 | One-cycle software release strobe |
| sda_drive | output | 1 | SDA output level |
| setup_ok | output | 1 | Setup time met; SCL may be released high |

## Verification
If the hold counter is loaded wrongly, or the profile register is taken at the wrong time, SDA moves on the wrong edge after SCL falls. That shows up within 3 or 12 cycles as an early or late data transition. A lost or stale release flag either stalls a gated bit indefinitely, with ready never rising, or drives it at hold expiry even though software has not released it. Both are visible within the same low period. A phase that fails to return to the high state leaves ready asserted past the rising edge, which shows 3 cycles after the raw SCL rises.

// File: rtl/sdat_pkg.sv
package sdat_pkg;
    typedef enum logic [2:0] {
        PH_HIGH     = 3'd0,
        PH_HOLD     = 3'd1,
        PH_WAIT_REL = 3'd2,
        PH_SETUP    = 3'd3,
        PH_READY    = 3'd4
    } phase_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/scl_sync_edge.sv
module scl_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    output logic scl_lvl,
    output logic scl_rise,
    output logic scl_fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = scl_raw;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        st_q <= st_d;
    end

    assign scl_lvl  = st_q.s2;
    assign scl_rise = st_q.s2 & ~st_q.prev;
    assign scl_fall = ~st_q.s2 & st_q.prev;
endmodule

// File: rtl/timing_profile.sv
module timing_profile #(
    parameter int unsigned HOLD_NORM   = 3,
    parameter int unsigned HOLD_EXT    = 12,
    parameter int unsigned SETUP_EXT   = 11,
    parameter int unsigned SETUP_SHORT = 1,
    parameter int unsigned FREE_CYCLES = 10,
    parameter int unsigned CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             ext_mode,
    output logic [CNT_W-1:0] hold_len,
    output logic [CNT_W-1:0] setup_plain,
    output logic [CNT_W-1:0] setup_gated,
    output logic             bus_idle,
    output logic             ext_active
);
    localparam int unsigned FREE_W   = $clog2(FREE_CYCLES + 1);
    localparam logic [FREE_W-1:0] FREE_LAST = FREE_W'(FREE_CYCLES - 1);

    typedef struct packed {
        logic [FREE_W-1:0] free_cnt;
        logic              ext;
    } prof_t;

    prof_t pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (!scl_lvl) begin
            pr_d.free_cnt = '0;
        end else if (pr_q.free_cnt != FREE_LAST) begin
            pr_d.free_cnt = pr_q.free_cnt + FREE_W'(1);
        end
        if (bus_idle) pr_d.ext = ext_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pr_q <= '{free_cnt: '0, ext: 1'b0};
        else        pr_q <= pr_d;
    end

    assign bus_idle    = scl_lvl && (pr_q.free_cnt == FREE_LAST);
    assign ext_active  = pr_q.ext;
    assign hold_len    = pr_q.ext ? CNT_W'(HOLD_EXT)  : CNT_W'(HOLD_NORM);
    assign setup_plain = pr_q.ext ? CNT_W'(SETUP_EXT) : CNT_W'(SETUP_SHORT);
    assign setup_gated = CNT_W'(SETUP_SHORT);
endmodule

// File: rtl/sda_phase_fsm.sv
module sda_phase_fsm
    import sdat_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic [CNT_W-1:0] hold_len,
    input  logic [CNT_W-1:0] setup_plain,
    input  logic [CNT_W-1:0] setup_gated,
    input  logic             data_bit,
    input  logic             gated_bit,
    input  logic             sw_release,
    output logic             sda_drive,
    output logic             setup_ok,
    output phase_e           phase
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             gated;
        logic             pend;
        logic             sda;
    } fsm_t;

    fsm_t fs_d, fs_q;
    logic released;

    assign released = fs_q.pend | sw_release;

    always_comb begin
        fs_d = fs_q;
        if (sw_release) fs_d.pend = 1'b1;

        if (scl_rise) begin
            fs_d.ph = PH_HIGH;
        end else if (scl_fall) begin
            fs_d.ph    = PH_HOLD;
            fs_d.cnt   = hold_len - CNT_W'(1);
            fs_d.gated = gated_bit;
        end else begin
            unique case (fs_q.ph)
                PH_HOLD: begin
                    if (fs_q.cnt != '0) begin
                        fs_d.cnt = fs_q.cnt - CNT_W'(1);
                    end else if (fs_q.gated && !released) begin
                        fs_d.ph = PH_WAIT_REL;
                    end else begin
                        fs_d.sda  = data_bit;
                        fs_d.pend = 1'b0;
                        fs_d.ph   = PH_SETUP;
                        fs_d.cnt  = (fs_q.gated ? setup_gated : setup_plain) - CNT_W'(1);
                    end
                end
                PH_WAIT_REL: begin
                    if (released) begin
                        fs_d.sda  = data_bit;
                        fs_d.pend = 1'b0;
                        fs_d.ph   = PH_SETUP;
                        fs_d.cnt  = setup_gated - CNT_W'(1);
                    end
                end
                PH_SETUP: begin
                    if (fs_q.cnt == '0) fs_d.ph = PH_READY;
                    else                fs_d.cnt = fs_q.cnt - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '{ph: PH_HIGH, cnt: '0, gated: 1'b0, pend: 1'b0, sda: 1'b1};
        else        fs_q <= fs_d;
    end

    assign sda_drive = fs_q.sda;
    assign setup_ok  = (fs_q.ph == PH_READY);
    assign phase     = fs_q.ph;
endmodule

// File: rtl/sda_setup_hold_timer.sv
module sda_setup_hold_timer
    import sdat_pkg::*;
#(
    parameter int unsigned HOLD_NORM   = 3,
    parameter int unsigned HOLD_EXT    = 12,
    parameter int unsigned SETUP_EXT   = 11,
    parameter int unsigned SETUP_SHORT = 1,
    parameter int unsigned FREE_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic ext_mode,
    input  logic data_bit,
    input  logic gated_bit,
    input  logic sw_release,
    output logic sda_drive,
    output logic setup_ok
);
    localparam int unsigned MAX_LEN = max2(max2(HOLD_NORM, HOLD_EXT), max2(SETUP_EXT, SETUP_SHORT));
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    logic             scl_lvl, scl_rise, scl_fall;
    logic [CNT_W-1:0] hold_len, setup_plain, setup_gated;
    logic             bus_idle, ext_active;
    phase_e           phase;

    scl_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_raw),
        .scl_lvl  (scl_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    timing_profile #(
        .HOLD_NORM   (HOLD_NORM),
        .HOLD_EXT    (HOLD_EXT),
        .SETUP_EXT   (SETUP_EXT),
        .SETUP_SHORT (SETUP_SHORT),
        .FREE_CYCLES (FREE_CYCLES),
        .CNT_W       (CNT_W)
    ) u_prof (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_lvl     (scl_lvl),
        .ext_mode    (ext_mode),
        .hold_len    (hold_len),
        .setup_plain (setup_plain),
        .setup_gated (setup_gated),
        .bus_idle    (bus_idle),
        .ext_active  (ext_active)
    );

    sda_phase_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .hold_len    (hold_len),
        .setup_plain (setup_plain),
        .setup_gated (setup_gated),
        .data_bit    (data_bit),
        .gated_bit   (gated_bit),
        .sw_release  (sw_release),
        .sda_drive   (sda_drive),
        .setup_ok    (setup_ok),
        .phase       (phase)
    );
endmodule

// File: rtl/sdat_checker.sv
module sdat_checker #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_lvl,
    input logic             scl_fall,
    input logic             sda_drive,
    input logic             setup_ok,
    input logic [CNT_W-1:0] hold_len,
    input logic             bus_idle,
    input logic             ext_active
);
    logic       chk_prev;
    logic [4:0] since_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_prev   <= 1'b1;
            since_fall <= '0;
        end else begin
            chk_prev <= scl_lvl;
            if (scl_fall)                 since_fall <= 5'd1;
            else if (since_fall != 5'd31) since_fall <= since_fall + 5'd1;
        end
    end

    AST_SDA_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && chk_prev) |=> $stable(sda_drive)); // R8

    AST_HOLD_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive != $past(sda_drive)) |-> ($past(since_fall) >= 5'($past(hold_len)))); // R2

    AST_READY_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ok |-> !chk_prev); // R8

    AST_SETUP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_ok) |-> $stable(sda_drive)); // R4

    AST_PROFILE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_idle) |-> $stable(ext_active)); // R9
endmodule

bind sda_setup_hold_timer sdat_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .scl_fall   (scl_fall),
    .sda_drive  (sda_drive),
    .setup_ok   (setup_ok),
    .hold_len   (hold_len),
    .bus_idle   (bus_idle),
    .ext_active (ext_active)
);

// File: tb/sda_setup_hold_timer_test.sv
module sda_setup_hold_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_raw = 1'b1;
    logic ext_mode = 1'b0;
    logic data_bit = 1'b1;
    logic gated_bit = 1'b0;
    logic sw_release = 1'b0;
    logic sda_drive, setup_ok;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic exp_sda = 1'b1;

    always #10 clk = ~clk;

    sda_setup_hold_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_raw    (scl_raw),
        .ext_mode   (ext_mode),
        .data_bit   (data_bit),
        .gated_bit  (gated_bit),
        .sw_release (sw_release),
        .sda_drive  (sda_drive),
        .setup_ok   (setup_ok)
    );

    // vector: {ext, gated, bit, release_cycle[4:0]}
    localparam int NV = 10;
    localparam logic [7:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 5'd0},
        {1'b0, 1'b0, 1'b1, 5'd0},
        {1'b1, 1'b0, 1'b0, 5'd0},
        {1'b1, 1'b0, 1'b1, 5'd0},
        {1'b0, 1'b1, 1'b0, 5'd0},
        {1'b0, 1'b1, 1'b1, 5'd12},
        {1'b1, 1'b1, 1'b0, 5'd20},
        {1'b1, 1'b1, 1'b1, 5'd4},
        {1'b0, 1'b1, 1'b0, 5'd6},
        {1'b0, 1'b1, 1'b1, 5'd5}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // SCL high long enough for the idle window (R9), SDA must not move (R8)
    task automatic idle_high(input int n);
        scl_raw = 1'b1;
        for (int i = 0; i < n; i++) begin
            cycle();
            if (i == 2) check("R8 ready drops after rise", int'(setup_ok), 0);
        end
        check("R8 sda quiet while high", int'(sda_drive), int'(exp_sda));
    endtask

    // one bit: fall, watch SDA change and ready rise
    task automatic run_bit(input string tag, input bit ext, input bit g, input bit b, input int r);
        int hold, dp, s;
        hold = ext ? 12 : 3;
        dp   = hold + 3;
        if (g && (r + 1 > dp)) dp = r + 1;
        s    = (g || !ext) ? 1 : 11;
        data_bit  = b;
        gated_bit = g;
        scl_raw   = 1'b0;
        sw_release = (g && r == 0);
        for (int n = 1; n <= dp + s; n++) begin
            cycle();
            sw_release = (g && r == n);
            if (n == dp - 1) check({tag, " sda before hold/release"}, int'(sda_drive), int'(exp_sda));
            if (n == dp)     check({tag, " sda driven"}, int'(sda_drive), int'(b));
            if (n == dp + s - 1) check({tag, " ready not yet"}, int'(setup_ok), 0);
            if (n == dp + s) check({tag, " ready up"}, int'(setup_ok), 1);
        end
        sw_release = 1'b0;
        exp_sda = b;
        cycle();
        check({tag, " ready held while low"}, int'(setup_ok), 1);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 sda after reset", int'(sda_drive), 1);
        check("R10 ready after reset", int'(setup_ok), 0);
        rst_n = 1'b1;
        cycle();

        for (int v = 0; v < NV; v++) begin
            logic [7:0] e;
            string tag;
            e = VEC[v];
            ext_mode = e[7];
            idle_high(20);
            if (!e[6]) tag = e[7] ? "R3 R4 ext plain" : "R1 R2 R5 norm plain";
            else if (e[4:0] <= 5'd4) tag = "R7 R6 early release";
            else tag = "R6 late release";
            run_bit(tag, e[7], e[6], e[5], int'(e[4:0]));
        end

        // R9: profile change mid-bit and in a short high period is ignored
        ext_mode = 1'b0;
        idle_high(20);
        run_bit("R2 norm base", 1'b0, 1'b0, 1'b0, 0);
        ext_mode = 1'b1;
        idle_high(5);
        run_bit("R9 short high keeps normal", 1'b0, 1'b0, 1'b1, 0);
        idle_high(20);
        run_bit("R9 long high takes extended", 1'b1, 1'b0, 1'b0, 0);

        // R6: gated bit with no release stays put, ready stays low
        ext_mode = 1'b0;
        idle_high(20);
        data_bit = 1'b1; gated_bit = 1'b1; scl_raw = 1'b0;
        for (int n = 0; n < 30; n++) cycle();
        check("R6 unreleased sda", int'(sda_drive), int'(exp_sda));
        check("R6 unreleased ready", int'(setup_ok), 0);
        sw_release = 1'b1;
        cycle();
        sw_release = 1'b0;
        check("R6 sda on release", int'(sda_drive), 1);
        check("R6 ready waits one", int'(setup_ok), 0);
        cycle();
        check("R6 ready after release", int'(setup_ok), 1);
        exp_sda = 1'b1;
        idle_high(6);

        // R10: reset mid-bit restores defaults
        scl_raw = 1'b0; data_bit = 1'b0; gated_bit = 1'b0;
        for (int n = 0; n < 8; n++) cycle();
        rst_n = 1'b0; scl_raw = 1'b1;
        cycle();
        check("R10 sda on reset", int'(sda_drive), 1);
        check("R10 ready on reset", int'(setup_ok), 0);
        rst_n = 1'b1;
        exp_sda = 1'b1;
        ext_mode = 1'b0;
        idle_high(20);
        run_bit("R10 normal profile after reset", 1'b0, 1'b0, 1'b0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule